// File: doc/BRIEF.md
# Parallel NOR Flash Word Program Sequencer

This block programs one word into an asynchronous parallel NOR flash and then waits until the device has finished. A request carries a word address, a data word and a completion-detection mode. The block runs four write bus cycles. The first two are unlock writes: 0x00AA to address 0x555, then 0x0055 to address 0x2AA. The third is the program command, 0x00A0 to address 0x555. The fourth writes the data word to the requested address. Each write-enable pulse is timed by counting clock cycles. Every timing minimum is a nanosecond parameter, rounded up to whole clock periods of `CLK_NS`.

After the last write the block watches for completion in one of two ways. In polling mode it reads the program address again and again. It finishes once bit 7 of the read word equals bit 7 of the word it wrote; while the device is still busy, it returns the complement of that bit. In ready-pin mode it ignores the busy pin for a short settling window, then waits for the pin to go high. A watchdog ends the wait with a failure flag if completion never comes.

Top module: `nor_prog_seq`

## Requirements
- R1: Out of reset, and whenever no request is being served, `flash_ce_n`, `flash_oe_n` and `flash_we_n` are 1, `flash_dq_oe` is 0, and `busy`, `done` and `fail` are 0.
- R2: An accepted request produces exactly four write cycles, in this order: (0x555, 0x00AA), (0x2AA, 0x0055), (0x555, 0x00A0), then (request address, request data). Each pair is (address, data) as seen at the rising edge of `flash_we_n`.
- R3: During every write, `flash_we_n` is low for at least 35 ns and high for at least 25 ns before the next fall. Falling edges are at least 70 ns apart. Chip-enable is low and output-enable is high while write-enable is low. `flash_dq_oe` is 1 at the rising edge, and the address does not change while write-enable is low.
- R4: The address holds for at least 45 ns after each falling edge of `flash_we_n`. The data word is stable for at least 35 ns before each rising edge.
- R5: In polling mode (`req_use_rdy`=0), reads go to the program address with output-enable low for at least 70 ns before sampling. `done` is raised only after a read in which bit 7 of `flash_dq_in` equals bit 7 of the programmed word.
- R6: `flash_dq_oe` is never 1 while `flash_oe_n` is 0. Output-enable falls only after the data bus has been released for at least 16 ns, and at least 16 ns after its previous rise.
- R7: In ready-pin mode (`req_use_rdy`=1), `flash_rdy` is ignored for at least 90 ns after the final write-enable rising edge. After that, `done` follows the first cycle in which `flash_rdy` is 1.
- R8: If completion is not seen, `done` and `fail` rise together exactly TIMEOUT_NS/CLK_NS (rounded up) plus the write-enable-high count, in cycles, after the final write-enable rising edge. `fail` is never 1 without `done`.
- R9: `done` is a one-cycle pulse in the cycle `busy` falls. `busy` is 1 from the cycle after acceptance until then. `req_valid` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a program operation (sampled when idle) |
| req_addr | input | ADDR_W | Word address to program |
| req_data | input | DATA_W | Word to program |
| req_use_rdy | input | 1 | 1: detect completion on the busy pin, 0: data polling |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | With `done`: completion wait timed out |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq_out | output | DATA_W | Data driven onto the flash data bus |
| flash_dq_oe | output | 1 | Drive enable for `flash_dq_out` |
| flash_dq_in | input | DATA_W | Data read from the flash data bus |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_rdy | input | 1 | Ready/busy pin, 1 = ready |

## Verification
A wrong command step shows up within one write cycle (about 72 ns) as a wrong address or data pair at a write-enable rising edge. A timer or state fault shows up at the next strobe edge as a pulse that is too short or a bus turnaround that is too quick. A wrong polling comparison or busy-window length shows up as a `done` before the modelled programming has finished, or as a timeout when it should have completed. The watchdog count can be checked to the exact cycle against the final write edge.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_BSY_WAIT,
    ST_RDY_WAIT,
    ST_RD_GAP,
    ST_RD_ACT
  } seq_state_e;

  localparam int unsigned N_CMD    = 4;
  localparam int unsigned POLL_BIT = 7;

  localparam logic [15:0] UNL_ADDR_A = 16'h0555;
  localparam logic [15:0] UNL_ADDR_B = 16'h02AA;
  localparam logic [7:0]  UNL_CODE_A = 8'hAA;
  localparam logic [7:0]  UNL_CODE_B = 8'h55;
  localparam logic [7:0]  PGM_CODE   = 8'hA0;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned usub(int unsigned a, int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

endpackage

// File: rtl/nor_phase_timer.sv
module nor_phase_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/nor_poll_watchdog.sv
module nor_poll_watchdog #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clear | (run & (cnt_q != LAST));

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run & (cnt_q == LAST);

endmodule

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
  import nor_prog_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IW     = 2
) (
  input  logic [IW-1:0]     idx,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  localparam logic [IW-1:0] LAST_IDX = IW'(N_CMD - 1);

  always_comb begin
    cmd_addr = prog_addr;
    cmd_data = prog_data;
    if (idx != LAST_IDX) begin
      case (idx)
        IW'(0): begin
          cmd_addr = ADDR_W'(UNL_ADDR_A);
          cmd_data = DATA_W'(UNL_CODE_A);
        end
        IW'(1): begin
          cmd_addr = ADDR_W'(UNL_ADDR_B);
          cmd_data = DATA_W'(UNL_CODE_B);
        end
        default: begin
          cmd_addr = ADDR_W'(UNL_ADDR_A);
          cmd_data = DATA_W'(PGM_CODE);
        end
      endcase
    end
  end

endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
  import nor_prog_pkg::*;
#(
  parameter int unsigned ADDR_W     = 21,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CLK_NS     = 8,
  parameter int unsigned T_WP_NS    = 35,
  parameter int unsigned T_WPH_NS   = 25,
  parameter int unsigned T_WC_NS    = 70,
  parameter int unsigned T_AH_NS    = 45,
  parameter int unsigned T_DS_NS    = 35,
  parameter int unsigned T_RC_NS    = 70,
  parameter int unsigned T_OE_NS    = 25,
  parameter int unsigned T_DF_NS    = 16,
  parameter int unsigned T_BUSY_NS  = 90,
  parameter int unsigned TIMEOUT_NS = 400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_use_rdy,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_dq_out,
  output logic              flash_dq_oe,
  input  logic [DATA_W-1:0] flash_dq_in,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n,
  input  logic              flash_rdy
);

  localparam int unsigned WLO_CYC = umax(1, umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS)));
  localparam int unsigned WHI_CYC = umax(umax(1, ns2cyc(T_WPH_NS, CLK_NS)),
                                         umax(usub(ns2cyc(T_WC_NS, CLK_NS), WLO_CYC),
                                              usub(ns2cyc(T_AH_NS, CLK_NS), WLO_CYC)));
  localparam int unsigned RD_CYC  = umax(1, umax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)));
  localparam int unsigned GAP_CYC = umax(1, ns2cyc(T_DF_NS, CLK_NS));
  localparam int unsigned BSY_CYC = umax(1, ns2cyc(T_BUSY_NS, CLK_NS));
  localparam int unsigned TO_CYC  = umax(2, ns2cyc(TIMEOUT_NS, CLK_NS));
  localparam int unsigned TMR_MAX = umax(umax(WLO_CYC, WHI_CYC), umax(umax(RD_CYC, GAP_CYC), BSY_CYC));
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned IW      = $clog2(N_CMD);

  localparam logic [TMR_W-1:0] LD_WLO = TMR_W'(WLO_CYC - 1);
  localparam logic [TMR_W-1:0] LD_WHI = TMR_W'(WHI_CYC - 1);
  localparam logic [TMR_W-1:0] LD_RD  = TMR_W'(RD_CYC - 1);
  localparam logic [TMR_W-1:0] LD_GAP = TMR_W'(GAP_CYC - 1);
  localparam logic [TMR_W-1:0] LD_BSY = TMR_W'(BSY_CYC - 1);
  localparam logic [IW-1:0]    LAST_STEP = IW'(N_CMD - 1);

  seq_state_e        state_q, state_d;
  logic [IW-1:0]     step_q, step_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [DATA_W-1:0] pd_q, pd_d;
  logic              mode_q, mode_d;

  logic              accept;
  logic              fin, fin_fail;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              wd_clr, wd_run, wd_exp;
  logic              polling;
  logic              poll_match;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic              wr_d;
  logic              unused_dq;

  assign unused_dq  = ^flash_dq_in;
  assign poll_match = (flash_dq_in[POLL_BIT] == pd_q[POLL_BIT]);
  assign polling    = (state_q == ST_BSY_WAIT) || (state_q == ST_RDY_WAIT) ||
                      (state_q == ST_RD_GAP)   || (state_q == ST_RD_ACT);
  assign wd_run     = polling;

  nor_phase_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  nor_poll_watchdog #(.LIMIT(TO_CYC)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (wd_clr),
    .run     (wd_run),
    .expired (wd_exp)
  );

  nor_cmd_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IW(IW)) u_rom (
    .idx       (step_d),
    .prog_addr (pa_d),
    .prog_data (pd_d),
    .cmd_addr  (rom_addr),
    .cmd_data  (rom_data)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    accept   = 1'b0;
    fin      = 1'b0;
    fin_fail = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    wd_clr   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          step_d   = '0;
          state_d  = ST_WR_LO;
          tmr_load = 1'b1;
          tmr_val  = LD_WLO;
        end
      end
      ST_WR_LO: begin
        if (tmr_exp) begin
          state_d  = ST_WR_HI;
          tmr_load = 1'b1;
          tmr_val  = LD_WHI;
        end
      end
      ST_WR_HI: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (step_q != LAST_STEP) begin
            step_d  = step_q + 1'b1;
            state_d = ST_WR_LO;
            tmr_val = LD_WLO;
          end else begin
            wd_clr = 1'b1;
            if (mode_q) begin
              state_d = ST_BSY_WAIT;
              tmr_val = LD_BSY;
            end else begin
              state_d = ST_RD_GAP;
              tmr_val = LD_GAP;
            end
          end
        end
      end
      ST_BSY_WAIT: begin
        if (tmr_exp) begin
          state_d = ST_RDY_WAIT;
        end
      end
      ST_RDY_WAIT: begin
        if (flash_rdy) begin
          fin = 1'b1;
        end
      end
      ST_RD_GAP: begin
        if (tmr_exp) begin
          state_d  = ST_RD_ACT;
          tmr_load = 1'b1;
          tmr_val  = LD_RD;
        end
      end
      ST_RD_ACT: begin
        if (tmr_exp) begin
          if (poll_match) begin
            fin = 1'b1;
          end else begin
            state_d  = ST_RD_GAP;
            tmr_load = 1'b1;
            tmr_val  = LD_GAP;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
    if (polling && wd_exp && !fin) begin
      fin      = 1'b1;
      fin_fail = 1'b1;
    end
    if (fin) begin
      state_d = ST_IDLE;
    end
  end

  assign pa_d   = accept ? req_addr    : pa_q;
  assign pd_d   = accept ? req_data    : pd_q;
  assign mode_d = accept ? req_use_rdy : mode_q;
  assign wr_d   = (state_d == ST_WR_LO) || (state_d == ST_WR_HI);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      step_q       <= '0;
      pa_q         <= '0;
      pd_q         <= '0;
      mode_q       <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      fail         <= 1'b0;
      flash_addr   <= '0;
      flash_dq_out <= '0;
      flash_dq_oe  <= 1'b0;
      flash_ce_n   <= 1'b1;
      flash_oe_n   <= 1'b1;
      flash_we_n   <= 1'b1;
    end else begin
      state_q      <= state_d;
      step_q       <= step_d;
      if (accept) begin
        pa_q   <= pa_d;
        pd_q   <= pd_d;
        mode_q <= mode_d;
      end
      busy         <= (state_d != ST_IDLE);
      done         <= fin;
      fail         <= fin_fail;
      flash_addr   <= wr_d ? rom_addr : pa_d;
      flash_dq_out <= rom_data;
      flash_dq_oe  <= wr_d;
      flash_ce_n   <= (state_d == ST_IDLE);
      flash_oe_n   <= (state_d != ST_RD_ACT);
      flash_we_n   <= (state_d != ST_WR_LO);
    end
  end

endmodule

module nor_prog_chk #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WP_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [DATA_W-1:0] flash_dq_out,
  input logic              flash_dq_oe,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic              flash_we_n
);

  logic [7:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
    end else if (!flash_we_n) begin
      if (lo_cnt != 8'hFF) lo_cnt <= lo_cnt + 1'b1;
    end else begin
      lo_cnt <= '0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe));

  p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> (lo_cnt >= 8'(WP_CYC)));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> (!flash_ce_n && flash_oe_n && flash_dq_oe));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_oe_n |-> !flash_dq_oe);

  p_fail_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind nor_prog_seq nor_prog_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WP_CYC (WLO_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .fail         (fail),
  .flash_addr   (flash_addr),
  .flash_dq_out (flash_dq_out),
  .flash_dq_oe  (flash_dq_oe),
  .flash_ce_n   (flash_ce_n),
  .flash_oe_n   (flash_oe_n),
  .flash_we_n   (flash_we_n)
);

// File: tb/test_nor_prog_seq.sv
`timescale 1ns/1ps
module test_nor_prog_seq;

  localparam int AW     = 21;
  localparam int DW     = 16;
  localparam int TO_CYC = 4000;
  localparam int WHI    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_use_rdy = 1'b0;
  logic          busy, done, fail;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_dq_out;
  logic          flash_dq_oe;
  logic [DW-1:0] flash_dq_in = '0;
  logic          flash_ce_n, flash_oe_n, flash_we_n;
  logic          flash_rdy = 1'b1;

  always #4 clk = ~clk;

  nor_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(8), .TIMEOUT_NS(TO_CYC * 8)) i_nor_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_use_rdy(req_use_rdy), .busy(busy), .done(done),
    .fail(fail), .flash_addr(flash_addr), .flash_dq_out(flash_dq_out),
    .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in), .flash_ce_n(flash_ce_n),
    .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n), .flash_rdy(flash_rdy)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural flash model
  real t_wef = -1000.0, t_wer = -1000.0, t_we4 = -1000.0, t_dq = -1000.0;
  real t_oef = -1000.0, t_oer = -1000.0, t_rel = -1000.0, t_prog_end = 0.0;
  real prog_ns = 1000.0;
  int  v3 = 0, v4 = 0, v6 = 0, wcnt = 0;
  bit  prog_busy = 0, never = 0, rdy_dropped = 0;
  logic [AW-1:0] pa = '0;
  logic [DW-1:0] pd = '0;
  logic [AW-1:0] wa [8];
  logic [DW-1:0] wd [8];

  always @(flash_dq_out) t_dq = $realtime;

  always @(flash_addr) begin
    if ($realtime > t_wef && $realtime - t_wef < 45.0) v4++;
  end

  always @(negedge flash_we_n) begin
    if ($realtime - t_wer < 25.0) v3++;
    if ($realtime - t_wef < 70.0) v3++;
    if (flash_ce_n || !flash_oe_n) v3++;
    t_wef = $realtime;
  end

  always @(posedge flash_we_n) begin
    if ($realtime - t_wef < 35.0) v3++;
    if ($realtime - t_dq < 35.0) v4++;
    if (!flash_dq_oe) v3++;
    t_wer = $realtime;
    if (wcnt < 8) begin
      wa[wcnt] = flash_addr;
      wd[wcnt] = flash_dq_out;
    end
    wcnt++;
    if (wcnt == 4) begin
      t_we4 = $realtime;
      pa = flash_addr;
      pd = flash_dq_out;
      prog_busy = 1;
      t_prog_end = $realtime + prog_ns;
    end
  end

  always @(negedge flash_oe_n) begin
    if ($realtime - t_oer < 16.0) v6++;
    if (flash_dq_oe || $realtime - t_rel < 16.0) v6++;
    t_oef = $realtime;
  end
  always @(posedge flash_oe_n) t_oer = $realtime;
  always @(negedge flash_dq_oe) t_rel = $realtime;

  always @(negedge clk) begin
    logic [DW-1:0] truth;
    if (prog_busy) begin
      if (!rdy_dropped && $realtime - t_we4 >= 85.0) begin
        flash_rdy <= 1'b0;
        rdy_dropped = 1;
      end
      if (!never && $realtime >= t_prog_end) begin
        prog_busy = 0;
        flash_rdy <= 1'b1;
      end
    end
    truth = prog_busy ? (pd ^ DW'(16'h0080)) : pd;
    if (!flash_oe_n && !flash_ce_n && ($realtime - t_oef >= 25.0) && flash_addr == pa)
      flash_dq_in <= truth;
    else
      flash_dq_in <= ~truth;
  end

  task automatic model_reset(input real pns, input bit nv);
    wcnt = 0; v3 = 0; v4 = 0; v6 = 0;
    prog_busy = 0; rdy_dropped = 0; never = nv; prog_ns = pns;
    flash_rdy <= 1'b1;
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit use_rdy,
                        input real pns, input bit nv);
    int cyc;
    real t_done;
    model_reset(pns, nv);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_use_rdy = use_rdy;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    repeat (20) @(negedge clk);
    // R9: a request while busy must be ignored
    req_valid = 1'b1; req_addr = ~a; req_data = ~d; req_use_rdy = ~use_rdy;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 6000) begin
      @(negedge clk);
      cyc++;
    end
    t_done = $realtime;
    check(done == 1'b1, "R9 done pulse seen", done, 1);
    check(busy == 1'b0, "R9 busy low with done", busy, 0);
    check(wcnt == 4 && wa[0] == AW'(12'h555) && wd[0] == 16'h00AA && wa[1] == AW'(12'h2AA) &&
          wd[1] == 16'h0055 && wa[2] == AW'(12'h555) && wd[2] == 16'h00A0,
          "R2 unlock and command cycles", wcnt, 4);
    check(wa[3] == a && wd[3] == d, "R2 program cycle", {wa[3], wd[3]}, {a, d});
    check(v3 == 0, "R3 write strobe timing", v3, 0);
    check(v4 == 0, "R4 address hold / data setup", v4, 0);
    check(v6 == 0, "R6 bus turnaround", v6, 0);
    if (nv) begin
      check(fail == 1'b1, "R8 timeout flags fail", fail, 1);
      check(int'((t_done - 4.0 - t_we4) / 8.0) == TO_CYC + WHI, "R8 timeout latency",
            int'((t_done - 4.0 - t_we4) / 8.0), TO_CYC + WHI);
    end else begin
      check(fail == 1'b0, use_rdy ? "R7 no fail" : "R5 no fail", fail, 0);
      check(t_done >= t_prog_end, use_rdy ? "R7 done not early" : "R5 done not early",
            longint'(t_done), longint'(t_prog_end));
      check(t_done - t_prog_end <= (use_rdy ? 24.0 : 200.0),
            use_rdy ? "R7 done latency" : "R5 done latency",
            longint'(t_done - t_prog_end), 0);
    end
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", done, 0);
    repeat (20) @(negedge clk);
    check(wcnt == 4 && !busy, "R9 ignored request caused no writes", wcnt, 4);
  endtask

  initial begin
    #(8.0 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe, "R1 strobes idle in reset",
          {flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail, "R1 status idle after reset", {busy, done, fail}, 0);
    check(flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe, "R1 strobes idle after reset",
          {flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe}, 4'b1110);
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'(32'h12345 + i * 32'h31415);
      d = DW'(16'h0F3C ^ (i * 16'h1111) ^ ((i % 2) ? 16'h0080 : 16'h0000));
      run_op(a, d, i[3], 9000.0 + 400.0 * (i % 8), 1'b0);
    end
    run_op(AW'(21'h0ABCD), 16'h5A5A, 1'b1, 400.0, 1'b0);
    run_op(AW'(21'h1FFFF), 16'h00FF, 1'b0, 14000.0, 1'b1);
    run_op(AW'(21'h00001), 16'hFF00, 1'b1, 14000.0, 1'b1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule